// File: doc/BRIEF.md
# Four-Phase Register Bus Slave

This block is a small register file that sits on a synchronous internal register bus. It holds the enables that steer a packet framer: payload scrambling, frame check sequence checking and byte alignment. It also keeps three event counters that the framer feeds with single-cycle pulses. The bus has separate 16-bit read and write data, a 4-bit word address, a read strobe, a select and a transfer acknowledge.

Each transfer is a full four-phase handshake. The master sets address, direction and write data, then raises select. The slave brings select and read through two flops and performs the access once. It then raises acknowledge and keeps it high until it sees select low again. Because of this the master and the slave may run on unrelated clocks. The slave drives zero on read data whenever acknowledge is low, and acknowledge itself is low when the slave is idle. Several slaves can therefore be merged with a plain OR.

The counters saturate at their maximum value and clear when they are read. Software samples them by reading them periodically.

Top module: `reg_bus_slave`

## Requirements
- R1: After reset, ack_o is 0, rdata_o is 0, all three enable outputs are 0 and every counter reads 0.
- R2: ack_o rises on the third rising clock edge after sel_i goes high (two synchronizer stages plus one register) and stays high while sel_i stays high.
- R3: After sel_i falls, ack_o stays high through two more rising edges and falls on the third.
- R4: Each handshake performs its register access exactly once, however long select is held; a counter read clears the counter only once, and events that arrive later in the same handshake are kept.
- R5: Word address 0 is the control register. A write stores all 16 bits of wdata_i, and a read returns them. Bit 0 drives scramble_en_o, bit 1 drives fcs_chk_en_o and bit 2 drives align_en_o.
- R6: Word addresses 1, 2 and 3 read the good-frame, FCS-error and abort counters. Each one-cycle pulse on the matching input adds one, and a counter holds at 2^CNT_W-1 once it reaches that value.
- R7: A counter read returns the value before the access and clears the counter. An event pulse in the same cycle as the clear leaves the counter at 1.
- R8: Writes to addresses 1 to 15 change no state: the enables, the control word and the counters keep their values.
- R9: Reads of addresses 4 to 15 return 0 and still complete the handshake.
- R10: rdata_o is 0 whenever ack_o is 0. While ack_o is high it holds the value captured for that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slave clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Transfer select from the bus master |
| rd_i | input | 1 | 1 = read, 0 = write; held stable while sel_i is high |
| addr_i | input | 4 | Word address; held stable while sel_i is high |
| wdata_i | input | 16 | Write data; held stable while sel_i is high |
| rdata_o | output | 16 | Read data; zero when not acknowledging |
| ack_o | output | 1 | Transfer acknowledge, four-phase |
| good_frame_i | input | 1 | One-cycle pulse per good frame |
| fcs_err_i | input | 1 | One-cycle pulse per FCS error |
| abort_i | input | 1 | One-cycle pulse per aborted frame |
| scramble_en_o | output | 1 | Scrambler enable (control bit 0) |
| fcs_chk_en_o | output | 1 | FCS check enable (control bit 1) |
| align_en_o | output | 1 | Byte alignment enable (control bit 2) |

## Verification
The bench samples acknowledge edge by edge on both phases of the handshake. A synchronizer with the wrong depth, or an acknowledge that follows select combinationally, moves the edge and is caught. It holds select long while events arrive. A slave that repeats the access on every cycle of a long select would clear the counter again and lose those events. Counters are driven from zero past saturation and read twice. One read is timed so that an event lands in the clear cycle, which catches a counter that wraps, never clears, or drops the coincident pulse. Writes are swept over every non-control address, and every unmapped address is read back. This catches decoders that alias, and read data that leaks out while the slave is idle and would break the OR merge.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;
  localparam int N_CNT  = 3;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;
endpackage

// File: rtl/rb_sync.sv
module rb_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/rb_handshake.sv
module rb_handshake (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_s_i,
  output logic ack_o,
  output logic strobe_o
);
  logic ack_q;

  // ack follows synchronized select; the access fires in the single cycle before ack rises
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= sel_s_i;
  end

  assign strobe_o = sel_s_i & ~ack_q;
  assign ack_o    = ack_q;

  AST_ACK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q && sel_s_i |=> ack_q); // R2
  AST_ACK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_s_i |=> !ack_q); // R3
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |=> !strobe_o); // R4
endmodule

// File: rtl/rb_sat_counter.sv
module rb_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         evt_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= evt_i ? W'(1) : '0;
    else if (evt_i && cnt_q != MAX) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;

  AST_CNT_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q == MAX && !clr_i |=> cnt_q == MAX); // R6
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && evt_i && cnt_q != MAX |=> cnt_q == $past(cnt_q) + W'(1)); // R6
  AST_CNT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q <= W'(1)); // R7
endmodule

// File: rtl/reg_bus_slave.sv
module reg_bus_slave
  import regbus_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ack_o,
  input  logic              good_frame_i,
  input  logic              fcs_err_i,
  input  logic              abort_i,
  output logic              scramble_en_o,
  output logic              fcs_chk_en_o,
  output logic              align_en_o
);
  logic [1:0]        sync_q;
  logic              sel_s, rd_s, ack_q, strobe, wr_stb, rd_stb;
  logic [DATA_W-1:0] ctrl_q, rdata_q, rd_val;
  logic [N_CNT-1:0]  evt, clr;
  logic [CNT_W-1:0]  cnt [N_CNT];

  rb_sync #(.W(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({rd_i, sel_i}),
    .q_o    (sync_q)
  );
  assign sel_s = sync_q[0];
  assign rd_s  = sync_q[1];

  rb_handshake u_hs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_s_i  (sel_s),
    .ack_o    (ack_q),
    .strobe_o (strobe)
  );

  assign wr_stb = strobe & ~rd_s;
  assign rd_stb = strobe &  rd_s;
  assign evt    = {abort_i, fcs_err_i, good_frame_i};

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    assign clr[g] = rd_stb && (addr_i == ADDR_W'(g + 1));
    rb_sat_counter #(.W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (evt[g]),
      .clr_i  (clr[g]),
      .cnt_o  (cnt[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ctrl_q <= '0;
    else if (wr_stb && addr_i == CTRL_ADDR) ctrl_q <= wdata_i;
  end

  always_comb begin
    rd_val = '0;
    if (addr_i == CTRL_ADDR) rd_val = ctrl_q;
    for (int i = 0; i < N_CNT; i++) begin
      if (addr_i == ADDR_W'(i + 1)) rd_val = DATA_W'(cnt[i]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (strobe) rdata_q <= rd_s ? rd_val : '0;
  end

  // zero when idle so several slaves can be ORed
  assign rdata_o       = ack_q ? rdata_q : '0;
  assign ack_o         = ack_q;
  assign scramble_en_o = ctrl_q[0];
  assign fcs_chk_en_o  = ctrl_q[1];
  assign align_en_o    = ctrl_q[2];

  AST_CTRL_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_stb && addr_i == CTRL_ADDR) |=> $stable(ctrl_q)); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q && $past(ack_q) |-> $stable(rdata_o)); // R10
endmodule

// File: tb/reg_bus_slave_bench.sv
module reg_bus_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 4;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sel = 1'b0, rd = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic        ack;
  logic [2:0]  evt = '0;
  logic        scr_en, fcs_en, aln_en;
  int          n_chk = 0, n_fail = 0;
  logic [15:0] rv, ctrl_exp;

  always #(CLK_PERIOD / 2) clk = ~clk;

  reg_bus_slave #(.CNT_W(CNT_W)) u_reg_bus_slave (
    .clk_i (clk), .rst_ni (rst_n), .sel_i (sel), .rd_i (rd), .addr_i (addr),
    .wdata_i (wdata), .rdata_o (rdata), .ack_o (ack),
    .good_frame_i (evt[0]), .fcs_err_i (evt[1]), .abort_i (evt[2]),
    .scramble_en_o (scr_en), .fcs_chk_en_o (fcs_en), .align_en_o (aln_en)
  );

  task automatic check(input string rq, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic access(input logic r, input logic [3:0] a, input logic [15:0] wd,
                        input int hold, output logic [15:0] val);
    @(negedge clk);
    rd = r; addr = a; wdata = wd; sel = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R2 ack low before third edge", 16'(ack), 16'd0);
    check("R10 rdata idle", rdata, 16'd0);
    @(posedge clk); @(negedge clk);
    check("R2 ack high", 16'(ack), 16'd1);
    val = rdata;
    for (int i = 0; i < hold; i++) begin
      @(posedge clk); @(negedge clk);
      check("R2 ack held", 16'(ack), 16'd1);
      check("R10 rdata held", rdata, val);
    end
    sel = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R3 ack after drop 1", 16'(ack), 16'd1);
    @(posedge clk); @(negedge clk);
    check("R3 ack after drop 2", 16'(ack), 16'd1);
    @(posedge clk); @(negedge clk);
    check("R3 ack cleared", 16'(ack), 16'd0);
    check("R10 rdata zero after", rdata, 16'd0);
  endtask

  task automatic pulse(input int k, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); evt[k] = 1'b1;
      @(negedge clk); evt[k] = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ack reset", 16'(ack), 16'd0);
    check("R1 rdata reset", rdata, 16'd0);
    check("R1 enables reset", 16'({aln_en, fcs_en, scr_en}), 16'd0);
    for (int a = 0; a < 4; a++) begin
      access(1'b1, 4'(a), 16'h0, 0, rv);
      check("R1 register reset", rv, 16'd0);
    end

    // R5 control sweep
    for (int v = 0; v < 16; v++) begin
      ctrl_exp = 16'((v * 16'h1357) ^ (v << 12) ^ v);
      access(1'b0, 4'd0, ctrl_exp, v % 3, rv);
      check("R5 enables", 16'({aln_en, fcs_en, scr_en}), ctrl_exp & 16'h7);
      access(1'b1, 4'd0, 16'hdead, 0, rv);
      check("R5 readback", rv, ctrl_exp);
    end

    // R8 writes elsewhere ignored
    pulse(0, 2);
    for (int a = 1; a < 16; a++) begin
      access(1'b0, 4'(a), 16'hffff ^ 16'(a), 0, rv);
      check("R8 enables kept", 16'({aln_en, fcs_en, scr_en}), ctrl_exp & 16'h7);
    end
    access(1'b1, 4'd0, 16'h0, 0, rv);
    check("R8 control kept", rv, ctrl_exp);
    access(1'b1, 4'd1, 16'h0, 0, rv);
    check("R8 counter kept", rv, 16'd2);

    // R9 unmapped reads
    for (int a = 4; a < 16; a++) begin
      access(1'b1, 4'(a), 16'h0, 1, rv);
      check("R9 unmapped zero", rv, 16'd0);
    end

    // R6/R7 counter sweep through saturation
    for (int k = 0; k < 3; k++) begin
      for (int n = 0; n <= CMAX + 2; n++) begin
        pulse(k, n);
        access(1'b1, 4'(k + 1), 16'h0, 0, rv);
        check("R6 count/saturate", rv, 16'((n > CMAX) ? CMAX : n));
        access(1'b1, 4'(k + 1), 16'h0, 0, rv);
        check("R7 cleared on read", rv, 16'd0);
      end
    end

    // R7 event coincident with clear
    pulse(1, 5);
    @(negedge clk);
    rd = 1'b1; addr = 4'd2; sel = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    evt[1] = 1'b1;
    @(posedge clk); @(negedge clk);
    evt[1] = 1'b0;
    check("R7 old value returned", rdata, 16'd5);
    sel = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    access(1'b1, 4'd2, 16'h0, 0, rv);
    check("R7 coincident event kept", rv, 16'd1);

    // R4 long select, events during the hold must survive
    pulse(2, 4);
    fork
      begin
        access(1'b1, 4'd3, 16'h0, 10, rv);
        check("R4 read value", rv, 16'd4);
      end
      begin
        repeat (6) @(negedge clk);
        pulse(2, 3);
      end
    join
    access(1'b1, 4'd3, 16'h0, 0, rv);
    check("R4 single clear per handshake", rv, 16'd3);

    finish_run();
  end
endmodule